// File: doc/BRIEF.md
# DMA Channel Chaining Controller

This controller strings logical DMA channels into queues. Each channel owns a link word that names a successor and carries two control bits: one that allows the hand-off and one that blocks it. When an active channel reports that its block is done, the controller drops that channel's run state. If linking is allowed and not blocked, it launches the named successor. Software only needs to launch the first channel of a queue, and the rest follow in order. A link that points back to an earlier channel, or to the channel itself, makes the queue repeat until software halts a member.

The channel engines that move the data sit outside this block. They see a one-cycle launch pulse and a run level per channel, and they report completion through a per-channel done pulse. The controller also keeps a per-channel interrupt-enable level. A launch sets it and a software stop clears it. A sticky error flag records every hand-off that could not be honoured.

Top module: `dma_chain_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every run level, launch pulse, interrupt enable, the error flag and every link word. After reset, completion of a channel hands off to nothing.
- R2: A software launch of an idle channel sets its run level and interrupt enable at the next edge and gives a one-cycle launch pulse. A software launch of a channel that is running and not finishing in that cycle has no effect.
- R3: A done pulse on a running channel whose link word has bit 15 set and bit 14 clear clears that channel. At the same edge it launches the channel named by the low log2(N) bits of the word, if that channel is free, with a launch pulse.
- R4: With bit 14 (stop-link) set, completion only clears the finishing channel. Setting the bit while the channel is running suppresses the hand-off of the block already in flight.
- R5: With bit 15 (enable-link) clear, completion only clears the finishing channel.
- R6: A chain whose links close into a loop, including a channel linked to itself, keeps relaunching on every completion until software stops a member.
- R7: A hand-off aimed at a channel that is running and not finishing is dropped and sets the error flag. When two finishing channels aim at the same free channel, it is launched once and the error flag is set.
- R8: A software stop clears the channel's run level and interrupt enable at the next edge. It beats a done pulse, a software launch and an incoming hand-off for that channel in the same cycle, and it suppresses that channel's own hand-off.
- R9: A done pulse on a channel that is not running has no effect.
- R10: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a link word |
| cfg_ch | input | IDW | Channel whose link word is written |
| cfg_data | input | 16 | Link word: bit 15 enable-link, bit 14 stop-link, low bits successor |
| start_vld | input | 1 | Software launch request |
| start_ch | input | IDW | Channel to launch |
| stop_vld | input | 1 | Software stop request |
| stop_ch | input | IDW | Channel to stop |
| blk_done | input | NCH | Per-channel block-completion pulses |
| ch_active | output | NCH | Per-channel run level |
| ch_start | output | NCH | Per-channel one-cycle launch pulse |
| ch_irq_en | output | NCH | Per-channel interrupt enable |
| link_err | output | 1 | Sticky hand-off error flag |

## Verification
The bench builds the block with its default of sixteen channels. Successor fields therefore span the full 0 to 15 range, and loops can involve arbitrary channel numbers, including a channel linked to itself. A behavioural model with plain integer arrays predicts the run levels, launch pulses, interrupt enables and error flag on every edge. That prediction covers same-cycle collisions: stop against launch, stop against done, and two hand-offs meeting at one target.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
    localparam int LINK_W       = 16;
    localparam int LNK_EN_BIT   = 15;
    localparam int LNK_STOP_BIT = 14;
    localparam int NXT_W        = 8;

    typedef struct packed {
        logic             en;
        logic             stop;
        logic [NXT_W-1:0] nxt;
    } link_t;

    function automatic link_t decode_link(input logic [LINK_W-1:0] w);
        link_t d;
        d.en   = w[LNK_EN_BIT];
        d.stop = w[LNK_STOP_BIT];
        d.nxt  = w[NXT_W-1:0];
        return d;
    endfunction
endpackage

// File: rtl/dcl_link_regs.sv
module dcl_link_regs
    import dcl_pkg::*;
#(
    parameter int NCH = 16,
    parameter int IDW = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDW-1:0]        wr_ch,
    input  logic [LINK_W-1:0]     wr_data,
    output link_t [NCH-1:0]       links
);
    always_ff @(posedge clk) begin
        if (rst) begin
            links <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_en && wr_ch == IDW'(i))
                    links[i] <= decode_link(wr_data);
            end
        end
    end
endmodule

// File: rtl/dcl_handoff.sv
module dcl_handoff
    import dcl_pkg::*;
#(
    parameter int NCH = 16,
    parameter int IDW = 4
) (
    input  link_t [NCH-1:0] links,
    input  logic  [NCH-1:0] fin,
    output logic  [NCH-1:0] hit,
    output logic  [NCH-1:0] multi
);
    logic [NCH-1:0] go;

    always_comb begin
        for (int i = 0; i < NCH; i++)
            go[i] = fin[i] & links[i].en & ~links[i].stop;
    end

    for (genvar t = 0; t < NCH; t++) begin : g_tgt
        logic [NCH-1:0] req;
        always_comb begin
            for (int i = 0; i < NCH; i++)
                req[i] = go[i] && (links[i].nxt[IDW-1:0] == IDW'(t));
        end
        assign hit[t]   = |req;
        assign multi[t] = ($countones(req) > 1);
    end
endmodule

// File: rtl/dcl_chan_state.sv
module dcl_chan_state #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] stop_hit,
    input  logic [NCH-1:0] start_hit,
    input  logic [NCH-1:0] done,
    input  logic [NCH-1:0] hit,
    input  logic [NCH-1:0] multi,
    output logic [NCH-1:0] fin,
    output logic [NCH-1:0] act_q,
    output logic [NCH-1:0] irq_q,
    output logic [NCH-1:0] start_q,
    output logic           err_q
);
    logic [NCH-1:0] busy;
    logic [NCH-1:0] launch;
    logic           err_set;

    always_comb begin
        fin     = done & act_q & ~stop_hit;
        busy    = act_q & ~fin;
        launch  = ~stop_hit & ~busy & (hit | start_hit);
        err_set = (|(hit & busy)) | (|multi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            irq_q   <= '0;
            start_q <= '0;
            err_q   <= 1'b0;
        end else begin
            act_q   <= (busy & ~stop_hit) | launch;
            irq_q   <= ~stop_hit & (irq_q | launch);
            start_q <= launch;
            err_q   <= err_q | err_set;
        end
    end

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dcl_pkg::*;
#(
    parameter  int NCH = 16,
    localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDW-1:0]    cfg_ch,
    input  logic [LINK_W-1:0] cfg_data,
    input  logic              start_vld,
    input  logic [IDW-1:0]    start_ch,
    input  logic              stop_vld,
    input  logic [IDW-1:0]    stop_ch,
    input  logic [NCH-1:0]    blk_done,
    output logic [NCH-1:0]    ch_active,
    output logic [NCH-1:0]    ch_start,
    output logic [NCH-1:0]    ch_irq_en,
    output logic              link_err
);
    link_t [NCH-1:0] links;
    logic  [NCH-1:0] stop_hit, start_hit, fin, hit, multi;

    always_comb begin
        stop_hit  = stop_vld  ? (NCH'(1) << stop_ch)  : '0;
        start_hit = start_vld ? (NCH'(1) << start_ch) : '0;
    end

    dcl_link_regs #(.NCH(NCH), .IDW(IDW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_ch(cfg_ch),
        .wr_data(cfg_data), .links(links)
    );

    dcl_handoff #(.NCH(NCH), .IDW(IDW)) u_hand (
        .links(links), .fin(fin), .hit(hit), .multi(multi)
    );

    dcl_chan_state #(.NCH(NCH)) u_state (
        .clk(clk), .rst(rst), .stop_hit(stop_hit), .start_hit(start_hit),
        .done(blk_done), .hit(hit), .multi(multi), .fin(fin),
        .act_q(ch_active), .irq_q(ch_irq_en), .start_q(ch_start),
        .err_q(link_err)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R8
        stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
            stop_hit[c] |=> (!ch_active[c] && !ch_irq_en[c]));
        // R2
        busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
            (start_hit[c] && ch_active[c] && !blk_done[c] && !stop_hit[c])
            |=> (ch_active[c] && !ch_start[c]));
        // R3
        handoff_launch_chk: assert property (@(posedge clk) disable iff (rst)
            (hit[c] && !ch_active[c] && !stop_hit[c]) |=> (ch_active[c] && ch_start[c]));
        // R7
        busy_target_err_chk: assert property (@(posedge clk) disable iff (rst)
            (hit[c] && ch_active[c] && !blk_done[c]) |=> link_err);
    end
endmodule

// File: tb/sim_dma_chain_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chain_ctrl;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_ch = '0;
    logic [15:0]   cfg_data = '0;
    logic          start_vld = 1'b0;
    logic [3:0]    start_ch = '0;
    logic          stop_vld = 1'b0;
    logic [3:0]    stop_ch = '0;
    logic [N-1:0]  blk_done = '0;
    logic [N-1:0]  ch_active, ch_start, ch_irq_en;
    logic          link_err;

    always #2 clk = ~clk;

    dma_chain_ctrl #(.NCH(N)) u0 (.*);

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    bit          m_act [N];
    bit          m_irq [N];
    bit          m_st  [N];
    bit          m_err;
    logic [15:0] m_lnk [N];

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic tick();
        int   cnt [N];
        bit   f [N];
        bit   sh, busy, launch;
        logic [N-1:0] ea, ei, es;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_act[i] = 0; m_irq[i] = 0; m_st[i] = 0; m_lnk[i] = '0;
            end
            m_err = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                cnt[i] = 0;
                sh = stop_vld && (stop_ch == i);
                f[i] = blk_done[i] && m_act[i] && !sh;
            end
            for (int i = 0; i < N; i++)
                if (f[i] && m_lnk[i][15] && !m_lnk[i][14])
                    cnt[m_lnk[i][3:0]] = cnt[m_lnk[i][3:0]] + 1;
            for (int t = 0; t < N; t++) begin
                sh = stop_vld && (stop_ch == t);
                busy = m_act[t] && !f[t];
                if ((cnt[t] > 0 && busy) || cnt[t] > 1) m_err = 1;
                launch = !sh && !busy && (cnt[t] > 0 || (start_vld && start_ch == t));
                m_act[t] = (busy && !sh) || launch;
                m_irq[t] = !sh && (m_irq[t] || launch);
                m_st[t]  = launch;
            end
            if (cfg_we) m_lnk[cfg_ch] = cfg_data;
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            ea[i] = m_act[i]; ei[i] = m_irq[i]; es[i] = m_st[i];
        end
        chk("active", 32'(ch_active), 32'(ea));
        chk("irq_en", 32'(ch_irq_en), 32'(ei));
        chk("start",  32'(ch_start),  32'(es));
        chk("err",    32'(link_err),  32'(m_err));
        cfg_we = 0; start_vld = 0; stop_vld = 0; blk_done = '0;
    endtask

    task automatic cfg(input int ch, input logic [15:0] d);
        cfg_we = 1; cfg_ch = 4'(ch); cfg_data = d; tick();
    endtask
    task automatic go(input int ch);
        start_vld = 1; start_ch = 4'(ch); tick();
    endtask
    task automatic halt(input int ch);
        stop_vld = 1; stop_ch = 4'(ch); tick();
    endtask
    task automatic fin(input int ch);
        blk_done[ch] = 1'b1; tick();
    endtask
    task automatic do_reset();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state and cleared link words
        tag = "R1";
        do_reset(); tick();
        cfg(0, 16'h8001);
        do_reset();
        go(0); fin(0); tick();
        // R2: launch, and launch of a running channel is ignored
        tag = "R2";
        go(2); tick(); go(2); tick();
        // R3: hand-off 2 -> 5
        tag = "R3";
        cfg(2, 16'h8005); fin(2); tick(); fin(5); tick();
        // R9: done on an idle channel
        tag = "R9";
        fin(7); tick();
        // R4: stop-link set up front, then set while running
        tag = "R4";
        cfg(1, 16'hC003); go(1); fin(1); tick();
        cfg(1, 16'h8003); go(1); cfg(1, 16'hC003); fin(1); tick();
        // R5: enable-link clear
        tag = "R5";
        cfg(4, 16'h0006); go(4); fin(4); tick();
        // R6: loop 8 -> 9 -> 10 -> 8 and a self-loop on 11
        tag = "R6";
        cfg(8, 16'h8009); cfg(9, 16'h800A); cfg(10, 16'h8008); cfg(11, 16'h800B);
        go(8);
        for (int r = 0; r < 3; r++) begin
            fin(8); fin(9); fin(10);
        end
        go(11); fin(11); fin(11); tick();
        halt(8); halt(11); tick();
        // R8: stop against done, stop against launch
        tag = "R8";
        cfg(12, 16'h800D); go(12);
        stop_vld = 1; stop_ch = 4'd12; blk_done[12] = 1'b1; tick(); tick();
        stop_vld = 1; stop_ch = 4'd14; start_vld = 1; start_ch = 4'd14; tick();
        // R7: hand-off into a running channel
        tag = "R7";
        cfg(3, 16'h8006); go(6); go(3); fin(3); tick();
        // R10: error persists
        tag = "R10";
        tick(); tick();
        halt(6);
        // R7: two sources meeting at one free target
        tag = "R7";
        do_reset();
        cfg(0, 16'h8006); cfg(1, 16'h8006); go(0); go(1);
        blk_done[0] = 1'b1; blk_done[1] = 1'b1; tick(); tick();
        tag = "R10";
        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule